// File: doc/BRIEF.md
# Frame-Synchronized Configuration Register File

This block is the configuration store for a streaming image core. The core needs three settings: a pixel gain, the number of active pixels per line, and a flag that routes the untouched input to the output instead of the processed result. Software reaches the block through an AXI-Lite slave port. Every setting has two copies. A write changes only the staged copy. The live copy, which drives the core, takes the staged value only when a start-of-frame pulse is seen. Because of this, a frame always runs with one consistent set of settings, however late in the frame software writes.

Software reads back the staged values. A read-only status word tells software whether any staged value still differs from its live copy, so it can tell when an update has reached the core. The write address and write data channels are accepted independently. Accesses to unmapped offsets complete normally and have no effect.

Top module: `cfg_shadow_regs`

## Requirements
- R1: After reset, the staged and live gain are 16, the staged and live line width are MAX_WIDTH, the staged and live bypass are 0, and the status word reads 0.
- R2: A write changes only the staged copy. The live outputs gain_o, width_o and bypass_o change only in the cycle after a clock edge at which frame_start is high. They then equal the staged values that held just before that edge.
- R3: A write to the width register (offset 0x04) with a 32-bit value greater than MAX_WIDTH stores MAX_WIDTH. Any other value is stored unchanged.
- R4: Reads return the staged value with all unused upper bits zero: gain in bits 7:0 at offset 0x00, width in bits clog2(MAX_WIDTH+1)-1:0 at offset 0x04, bypass in bit 0 at offset 0x08.
- R5: Offset 0x0C reads bit 0 as 1 exactly when at least one staged value differs from its live copy, with the other bits 0. Writes to 0x0C change nothing.
- R6: A write to an offset other than 0x00, 0x04, 0x08 or 0x0C changes no register and is answered with response 0 (OKAY). A read of such an offset returns 0 with response 0.
- R7: The write address and write data channels may complete in either order or in the same cycle. Each write produces exactly one write response. bvalid stays high until bready is seen, and no new address or data is accepted while a response is pending.
- R8: A read returns its data one cycle after the address handshake. rvalid and rdata stay stable until rready is seen, and arready is low while a read response is pending.
- R9: If a write completes in the same cycle as frame_start, the live copy takes the previously staged value. The new value stays staged, and status bit 0 reads 1.
- R10: The gain register keeps only bits 7:0 of the write data, and the bypass register keeps only bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| frame_start | input | 1 | Start-of-frame pulse; loads the live copies |
| gain_o | output | 8 | Live gain |
| width_o | output | clog2(MAX_WIDTH+1) | Live active line width |
| bypass_o | output | 1 | Live bypass flag |

## Verification
The assertions check, on every cycle, the rules that can be stated cycle by cycle. The live outputs hold still unless a frame pulse came before. After a pulse they equal the previous staged gain. The live width never exceeds MAX_WIDTH. Both response channels hold while stalled and always answer OKAY. The bench scenarios cover what depends on the data values themselves. These are the full sweeps of gain values and of width values around the clamp limit, the status word tracking staged against live copies, writes to unmapped and read-only offsets having no visible effect, the three channel orderings, and a write landing in the same cycle as a frame pulse.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
   localparam int OFS_GAIN   = 'h00;
   localparam int OFS_WIDTH  = 'h04;
   localparam int OFS_BYPASS = 'h08;
   localparam int OFS_STATUS = 'h0C;
   localparam int DATA_W     = 32;
   localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/cfg_reg_slot.sv
module cfg_reg_slot #(
   parameter int W = 8,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_val,
   input  logic         load,
   output logic [W-1:0] stage_q,
   output logic [W-1:0] live_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_q <= RST_VAL;
         live_q  <= RST_VAL;
      end else begin
         if (wr_en) stage_q <= wr_val;
         if (load)  live_q  <= stage_q;
      end
   end
endmodule

// File: rtl/axil_wr_port.sv
module axil_wr_port #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic              awvalid,
   output logic              awready,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wvalid,
   output logic              wready,
   output logic              bvalid,
   input  logic              bready,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   logic              aw_held, w_held;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              aw_hs, w_hs;

   assign awready = !aw_held && !bvalid;
   assign wready  = !w_held && !bvalid;
   assign aw_hs   = awvalid && awready;
   assign w_hs    = wvalid && wready;
   assign wr_en   = (aw_held || aw_hs) && (w_held || w_hs);
   assign wr_addr = aw_held ? addr_q : awaddr;
   assign wr_data = w_held ? data_q : wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aw_held <= 1'b0;
         w_held  <= 1'b0;
         bvalid  <= 1'b0;
         addr_q  <= '0;
         data_q  <= '0;
      end else begin
         if (wr_en) begin
            aw_held <= 1'b0;
            w_held  <= 1'b0;
            bvalid  <= 1'b1;
         end else begin
            if (aw_hs) begin
               aw_held <= 1'b1;
               addr_q  <= awaddr;
            end
            if (w_hs) begin
               w_held <= 1'b1;
               data_q <= wdata;
            end
            if (bvalid && bready) bvalid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/axil_rd_port.sv
module axil_rd_port #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arvalid,
   output logic              arready,
   input  logic [DATA_W-1:0] word,
   output logic              rvalid,
   output logic [DATA_W-1:0] rdata,
   input  logic              rready
);
   assign arready = !rvalid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
      end else if (arvalid && arready) begin
         rvalid <= 1'b1;
         rdata  <= word;
      end else if (rvalid && rready) begin
         rvalid <= 1'b0;
      end
   end
endmodule

// File: rtl/cfg_shadow_regs.sv
module cfg_shadow_regs
   import cfg_pkg::*;
#(
   parameter int MAX_WIDTH = 1920,
   parameter int ADDR_W    = 6,
   parameter int GAIN_RST  = 16,
   localparam int W_BITS   = $clog2(MAX_WIDTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [31:0]       s_wdata,
   input  logic              s_wvalid,
   output logic              s_wready,
   output logic [1:0]        s_bresp,
   output logic              s_bvalid,
   input  logic              s_bready,
   input  logic [ADDR_W-1:0] s_araddr,
   input  logic              s_arvalid,
   output logic              s_arready,
   output logic [31:0]       s_rdata,
   output logic [1:0]        s_rresp,
   output logic              s_rvalid,
   input  logic              s_rready,
   input  logic              frame_start,
   output logic [7:0]        gain_o,
   output logic [W_BITS-1:0] width_o,
   output logic              bypass_o
);
   localparam logic [ADDR_W-1:0] LOW2 = ADDR_W'(3);

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("ADDR_W must cover the four mapped words");
      end
      if (MAX_WIDTH < 1 || W_BITS > DATA_W) begin : g_bad_width
         $error("MAX_WIDTH out of range");
      end
      if (GAIN_RST < 0 || GAIN_RST > 255) begin : g_bad_gain
         $error("GAIN_RST must fit in 8 bits");
      end
   endgenerate

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
      return (a | LOW2) == (ADDR_W'(ofs) | LOW2);
   endfunction

   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [31:0]       wr_data;
   logic [31:0]       rd_word;

   logic [7:0]        gain_stage;
   logic [W_BITS-1:0] width_stage, width_wr;
   logic              bypass_stage;
   logic              pending;

   axil_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
      .clk, .rst_n,
      .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
      .wdata(s_wdata), .wvalid(s_wvalid), .wready(s_wready),
      .bvalid(s_bvalid), .bready(s_bready),
      .wr_en, .wr_addr, .wr_data
   );

   axil_rd_port #(.DATA_W(DATA_W)) u_rd (
      .clk, .rst_n,
      .arvalid(s_arvalid), .arready(s_arready),
      .word(rd_word), .rvalid(s_rvalid), .rdata(s_rdata), .rready(s_rready)
   );

   assign s_bresp = RESP_OKAY;
   assign s_rresp = RESP_OKAY;

   assign width_wr = (wr_data > DATA_W'(MAX_WIDTH)) ? W_BITS'(MAX_WIDTH)
                                                    : wr_data[W_BITS-1:0];

   cfg_reg_slot #(.W(8), .RST_VAL(8'(GAIN_RST))) u_gain (
      .clk, .rst_n,
      .wr_en(wr_en && hit(wr_addr, OFS_GAIN)), .wr_val(wr_data[7:0]),
      .load(frame_start), .stage_q(gain_stage), .live_q(gain_o)
   );

   cfg_reg_slot #(.W(W_BITS), .RST_VAL(W_BITS'(MAX_WIDTH))) u_width (
      .clk, .rst_n,
      .wr_en(wr_en && hit(wr_addr, OFS_WIDTH)), .wr_val(width_wr),
      .load(frame_start), .stage_q(width_stage), .live_q(width_o)
   );

   cfg_reg_slot #(.W(1), .RST_VAL(1'b0)) u_bypass (
      .clk, .rst_n,
      .wr_en(wr_en && hit(wr_addr, OFS_BYPASS)), .wr_val(wr_data[0]),
      .load(frame_start), .stage_q(bypass_stage), .live_q(bypass_o)
   );

   assign pending = (gain_stage != gain_o) || (width_stage != width_o)
                 || (bypass_stage != bypass_o);

   always_comb begin
      rd_word = '0;
      if (hit(s_araddr, OFS_GAIN))        rd_word[7:0]        = gain_stage;
      else if (hit(s_araddr, OFS_WIDTH))  rd_word[W_BITS-1:0] = width_stage;
      else if (hit(s_araddr, OFS_BYPASS)) rd_word[0]          = bypass_stage;
      else if (hit(s_araddr, OFS_STATUS)) rd_word[0]          = pending;
   end
endmodule

// File: rtl/cfg_shadow_regs_chk.sv
module cfg_shadow_regs_chk #(
   parameter int MAX_WIDTH = 1920,
   localparam int W_BITS = $clog2(MAX_WIDTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_start,
   input logic [7:0]        gain_o,
   input logic [W_BITS-1:0] width_o,
   input logic              bypass_o,
   input logic [7:0]        gain_stage,
   input logic              s_bvalid,
   input logic              s_bready,
   input logic [1:0]        s_bresp,
   input logic              s_awready,
   input logic              s_rvalid,
   input logic              s_rready,
   input logic [31:0]       s_rdata,
   input logic [1:0]        s_rresp,
   input logic              s_arready
);
   a_r2_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(frame_start) |-> ($stable(gain_o) && $stable(width_o) && $stable(bypass_o)));

   a_r2_live_load: assert property (@(posedge clk) disable iff (!rst_n)
      $past(frame_start) |-> gain_o == $past(gain_stage));

   a_r3_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
      width_o <= W_BITS'(MAX_WIDTH));

   a_r6_bresp_okay: assert property (@(posedge clk) disable iff (!rst_n)
      s_bvalid |-> s_bresp == 2'b00);

   a_r7_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (s_bvalid && !s_bready) |=> s_bvalid);

   a_r7_no_aw_while_b: assert property (@(posedge clk) disable iff (!rst_n)
      s_bvalid |-> !s_awready);

   a_r8_r_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));

   a_r8_no_ar_while_r: assert property (@(posedge clk) disable iff (!rst_n)
      s_rvalid |-> (!s_arready && s_rresp == 2'b00));
endmodule

bind cfg_shadow_regs cfg_shadow_regs_chk #(.MAX_WIDTH(MAX_WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
   .gain_o(gain_o), .width_o(width_o), .bypass_o(bypass_o),
   .gain_stage(gain_stage),
   .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
   .s_awready(s_awready),
   .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
   .s_rresp(s_rresp), .s_arready(s_arready)
);

// File: tb/cfg_shadow_regs_bench.sv
module cfg_shadow_regs_bench;
   localparam int MAXW = 40;
   localparam int WB   = $clog2(MAXW + 1);
   localparam int AW   = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] awaddr = '0, araddr = '0;
   logic          awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0;
   logic          arvalid = 1'b0, rready = 1'b0, frame_start = 1'b0;
   logic [31:0]   wdata = '0;
   logic          awready, wready, bvalid, arready, rvalid, bypass_o;
   logic [1:0]    bresp, rresp;
   logic [31:0]   rdata;
   logic [7:0]    gain_o;
   logic [WB-1:0] width_o;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   cfg_shadow_regs #(.MAX_WIDTH(MAXW), .ADDR_W(AW), .GAIN_RST(16)) u_cfg_shadow_regs (
      .clk, .rst_n,
      .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
      .s_wdata(wdata), .s_wvalid(wvalid), .s_wready(wready),
      .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
      .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
      .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
      .frame_start, .gain_o, .width_o, .bypass_o
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   // mode 0: same cycle, 1: address first, 2: data first
   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input int mode, input int hold);
      @(negedge clk);
      if (mode != 2) begin awvalid = 1'b1; awaddr = a; end
      if (mode != 1) begin wvalid = 1'b1; wdata = d; end
      @(posedge clk);
      @(negedge clk);
      awvalid = 1'b0; wvalid = 1'b0;
      if (mode == 1) begin wvalid = 1'b1; wdata = d; end
      if (mode == 2) begin awvalid = 1'b1; awaddr = a; end
      if (mode != 0) begin
         chk("R7 no response before both channels", 32'(bvalid), 0);
         @(posedge clk);
         @(negedge clk);
         awvalid = 1'b0; wvalid = 1'b0;
      end
      for (int i = 0; i < hold; i++) begin
         chk("R7 bvalid held", 32'(bvalid), 1);
         chk("R7 awready low while response pending", 32'(awready), 0);
         @(negedge clk);
      end
      chk("R7 response valid OKAY", {29'd0, bvalid, bresp}, 32'h4);
      bready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bready = 1'b0;
      chk("R7 single response", 32'(bvalid), 0);
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d, input int hold);
      @(negedge clk);
      arvalid = 1'b1; araddr = a;
      @(posedge clk);
      @(negedge clk);
      arvalid = 1'b0;
      d = rdata;
      for (int i = 0; i < hold; i++) begin
         chk("R8 rvalid held", 32'(rvalid), 1);
         chk("R8 rdata stable", rdata, d);
         chk("R8 arready low while pending", 32'(arready), 0);
         @(negedge clk);
      end
      chk("R8 read valid OKAY", {29'd0, rvalid, rresp}, 32'h4);
      rready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rready = 1'b0;
   endtask

   task automatic frame();
      @(negedge clk);
      frame_start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      frame_start = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 gain_o reset", 32'(gain_o), 16);
      chk("R1 width_o reset", 32'(width_o), MAXW);
      chk("R1 bypass_o reset", 32'(bypass_o), 0);
      rd(6'h00, d, 0); chk("R1 staged gain reset", d, 16);
      rd(6'h04, d, 0); chk("R1 staged width reset", d, MAXW);
      rd(6'h08, d, 0); chk("R1 staged bypass reset", d, 0);
      rd(6'h0C, d, 0); chk("R1 status reset", d, 0);

      // R10 / R2 / R4 gain sweep with junk upper bits, rotating channel order
      for (int v = 0; v < 256; v++) begin
         wr(6'h00, {8'hA5, 8'(v * 7), 8'h3C, 8'(v)}, v % 3, 0);
         chk("R2 gain_o unchanged before frame", 32'(gain_o), (v == 0) ? 16 : v - 1);
         rd(6'h00, d, 0); chk("R10 R4 gain readback", d, v);
         frame();
         chk("R2 gain_o after frame", 32'(gain_o), v);
      end

      // R3 width sweep around the clamp limit
      for (int v = 0; v <= MAXW + 8; v++) begin
         wr(6'h04, 32'(v), 0, 0);
         rd(6'h04, d, 0);
         chk("R3 R4 width readback", d, (v > MAXW) ? MAXW : v);
         frame();
         chk("R3 width_o after frame", 32'(width_o), (v > MAXW) ? MAXW : v);
      end
      wr(6'h04, 32'hFFFF_FFFF, 1, 0);
      rd(6'h04, d, 0); chk("R3 huge width clamps", d, MAXW);
      wr(6'h04, 32'h0001_0005, 2, 0);
      rd(6'h04, d, 0); chk("R3 large width clamps", d, MAXW);
      frame();
      chk("R3 width_o clamped", 32'(width_o), MAXW);

      // R10 bypass keeps bit 0 only
      wr(6'h08, 32'hFFFF_FFFE, 0, 0);
      rd(6'h08, d, 0); chk("R10 bypass even value", d, 0);
      wr(6'h08, 32'h8000_0003, 0, 2);
      rd(6'h08, d, 3); chk("R10 R4 bypass readback", d, 1);
      chk("R2 bypass_o before frame", 32'(bypass_o), 0);

      // R5 status tracking
      rd(6'h0C, d, 0); chk("R5 status pending", d, 1);
      frame();
      chk("R2 bypass_o after frame", 32'(bypass_o), 1);
      rd(6'h0C, d, 0); chk("R5 status clear after frame", d, 0);
      wr(6'h04, 32'(MAXW), 0, 0);
      rd(6'h0C, d, 0); chk("R5 same-value write not pending", d, 0);
      wr(6'h0C, 32'hFFFF_FFFF, 1, 0);
      rd(6'h0C, d, 0); chk("R5 status write ignored", d, 0);
      rd(6'h00, d, 0); chk("R5 gain untouched by status write", d, 255);

      // R6 unmapped accesses
      for (int a = 16; a < 64; a += 4) begin
         wr(6'(a), 32'h0000_0021, a % 3, 0);
         rd(6'(a), d, 0);
         chk("R6 unmapped read zero", d, 0);
      end
      rd(6'h00, d, 0); chk("R6 gain unchanged", d, 255);
      rd(6'h04, d, 0); chk("R6 width unchanged", d, MAXW);
      rd(6'h08, d, 0); chk("R6 bypass unchanged", d, 1);
      rd(6'h0C, d, 0); chk("R6 status unchanged", d, 0);
      frame();
      chk("R6 gain_o unchanged", 32'(gain_o), 255);
      chk("R6 width_o unchanged", 32'(width_o), MAXW);

      // R9 write in the same cycle as frame_start
      wr(6'h00, 32'd50, 0, 0);
      @(negedge clk);
      awvalid = 1'b1; awaddr = 6'h00; wvalid = 1'b1; wdata = 32'd77;
      frame_start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      awvalid = 1'b0; wvalid = 1'b0; frame_start = 1'b0;
      chk("R9 live takes previous staged", 32'(gain_o), 50);
      bready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bready = 1'b0;
      rd(6'h00, d, 0); chk("R9 new value staged", d, 77);
      rd(6'h0C, d, 0); chk("R9 status pending", d, 1);
      frame();
      chk("R9 applied next frame", 32'(gain_o), 77);

      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule